// File: doc/BRIEF.md
# Assumed-Latency Writeback Delay Buffer

This block sits between the result outputs of several functional units and the write ports of a register file in a statically scheduled wide-issue core. The compiler schedules every operation against a fixed assumed latency. Real units may finish sooner. The buffer keeps each early result and writes it to the register file in exactly the cycle the compiler expects. The destination register therefore keeps its old value until then, and the code never sees how fast a unit really is.

The block runs a free-running cycle stamp, `now_o`. The issue stage tags each operation with this stamp. When a unit returns a result, it presents the stamp of issue, the opcode's assumed latency, the destination index and the data. The buffer loads a countdown from these values and stores the entry. When the countdown expires, the entry is sent out on one of two register-file write ports.

A per-register pending flag tells the issue stage which registers still have a write in flight. A stall output warns the issue stage before the buffer runs out of free entries.

Top module: `wbdb_top`

## Requirements
- R1: `now_o` is 0 in the first cycle after reset, rises by one every cycle, and wraps modulo 2^TS_W.
- R2: A result presented in cycle A with stamp T and assumed latency L, where the elapsed count A−T (mod 2^TS_W) is below L, is written on a write port (`wr_en_o` bit high, with matching `wr_addr_o` and `wr_data_o` slice) in cycle T+L exactly. No accepted result is dropped.
- R3: A result whose elapsed count is L or more is late. It is written in the cycle after it arrives. `late_err_o` goes high from the next cycle and stays high until reset.
- R4: Up to two results due in the same cycle are written together, one on each port. The assignment of results to port 0 and port 1 carries no meaning.
- R5: If both results due in a cycle target the same register, only the data of the later-issued one (the smaller elapsed count) is written. The two ports never carry the same address in one cycle.
- R6: `pend_o[r]` rises in the cycle after an issue to register r. It falls in the cycle after a writeback that retires a result for r. If an issue and a retire for r fall in the same cycle, the issue wins.
- R7: `stall_o` is high exactly when fewer than STALL_FREE of the DEPTH entries are free. An entry is occupied from the cycle after its result arrives up to and including the cycle it is written.
- R8: During reset, no write port is enabled, every pending flag is clear, and `stall_o` and `late_err_o` are low.
- R9: No write appears before its assumed cycle. A result that arrives with many cycles to spare, including one presented in its issue cycle, is held back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| now_o | output | TS_W | Cycle stamp for tagging issued operations |
| issue_vld_i | input | NUM_FU | One bit per issue slot: an operation is issued this cycle |
| issue_dest_i | input | NUM_FU*REG_W | Destination register per issue slot |
| res_vld_i | input | NUM_FU | One bit per unit: a result is presented this cycle |
| res_dest_i | input | NUM_FU*REG_W | Destination register per unit result |
| res_data_i | input | NUM_FU*DATA_W | Result data per unit |
| res_ts_i | input | NUM_FU*TS_W | Issue stamp per unit result |
| res_lat_i | input | NUM_FU*LAT_W | Assumed latency per unit result |
| wr_en_o | output | 2 | Write enable per register-file port |
| wr_addr_o | output | 2*REG_W | Write address per port |
| wr_data_o | output | 2*DATA_W | Write data per port |
| pend_o | output | 2^REG_W | Pending-write flag per register |
| stall_o | output | 1 | Issue backpressure: free entries below threshold |
| late_err_o | output | 1 | Sticky flag: a result came back after its assumed latency |

## Verification
The bench aims at the latency extremes. These are a latency of one with the result presented in its issue cycle, and a latency of 31 with the result arriving either at once or on the last allowed cycle. A countdown that is off by one moves these writes a cycle early or late, and the write-set comparison catches it. Two results for one register that fall due together check the issue-order rule: a design that compares stamps the wrong way writes the stale value, and one that ignores the clash drives both ports to the same address. A late result checks that the write still happens and that the error flag latches and stays set. A burst of long-latency results fills the buffer, so a wrong free count shows up as a stall that rises or falls at the wrong moment. Long random runs wrap the stamp many times, which breaks any elapsed-count arithmetic done without modulo.

// File: rtl/wbdb_pkg.sv
package wbdb_pkg;
  localparam int unsigned WB_PORTS = 2;

  typedef enum logic {
    ARR_ON_TIME = 1'b0,
    ARR_LATE    = 1'b1
  } arr_kind_e;
endpackage

// File: rtl/wbdb_pend.sv
module wbdb_pend #(
  parameter int unsigned NUM_FU = 2,
  parameter int unsigned REG_W  = 7,
  parameter int unsigned NUM_WP = 2,
  localparam int unsigned NREG  = 1 << REG_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_FU-1:0]        issue_vld_i,
  input  logic [NUM_FU*REG_W-1:0]  issue_dest_i,
  input  logic [NUM_WP-1:0]        clr_vld_i,
  input  logic [NUM_WP*REG_W-1:0]  clr_dest_i,
  output logic [NREG-1:0]          pend_o
);
  logic [NREG-1:0] pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    for (int w = 0; w < NUM_WP; w++)
      if (clr_vld_i[w]) pend_d[clr_dest_i[w*REG_W +: REG_W]] = 1'b0;
    // issue after retire: a fresh issue keeps the flag
    for (int f = 0; f < NUM_FU; f++)
      if (issue_vld_i[f]) pend_d[issue_dest_i[f*REG_W +: REG_W]] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;

  assign pend_o = pend_q;

  for (genvar f = 0; f < NUM_FU; f++) begin : g_set_chk
    // R6
    pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      issue_vld_i[f] |=> pend_q[$past(issue_dest_i[f*REG_W +: REG_W])]);
  end
endmodule

// File: rtl/wbdb_store.sv
module wbdb_store #(
  parameter int unsigned NUM_FU     = 2,
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned REG_W      = 7,
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned LAT_W      = 5,
  parameter int unsigned TS_W       = 8,
  parameter int unsigned STALL_FREE = 4,
  localparam int unsigned NWP       = wbdb_pkg::WB_PORTS,
  localparam int unsigned IDX_W     = $clog2(DEPTH),
  localparam int unsigned CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [TS_W-1:0]            now_i,
  input  logic [NUM_FU-1:0]          res_vld_i,
  input  logic [NUM_FU*REG_W-1:0]    res_dest_i,
  input  logic [NUM_FU*DATA_W-1:0]   res_data_i,
  input  logic [NUM_FU*TS_W-1:0]     res_ts_i,
  input  logic [NUM_FU*LAT_W-1:0]    res_lat_i,
  output logic [NWP-1:0]             ret_vld_o,
  output logic [NWP*REG_W-1:0]       ret_dest_o,
  output logic [NWP*DATA_W-1:0]      ret_data_o,
  output logic [NWP*TS_W-1:0]        ret_age_o,
  output logic [NUM_FU-1:0]          late_o,
  output logic                       stall_o
);
  import wbdb_pkg::*;

  typedef struct packed {
    logic [REG_W-1:0]  dest;
    logic [DATA_W-1:0] data;
    logic [TS_W-1:0]   ts;
    logic [LAT_W-1:0]  cnt;
  } ent_t;

  ent_t             ent_q [DEPTH];
  logic [DEPTH-1:0] vld_q;

  // free-slot allocation, one per unit
  logic [IDX_W-1:0]  slot    [NUM_FU];
  logic [NUM_FU-1:0] slot_ok;
  logic [DEPTH-1:0]  taken;

  always_comb begin
    taken = vld_q;
    for (int f = 0; f < NUM_FU; f++) begin
      slot[f]    = '0;
      slot_ok[f] = 1'b0;
      for (int i = 0; i < DEPTH; i++)
        if (!taken[i] && !slot_ok[f]) begin
          slot[f]    = IDX_W'(i);
          slot_ok[f] = 1'b1;
        end
      if (slot_ok[f]) taken[slot[f]] = 1'b1;
    end
  end

  // arrival countdown
  arr_kind_e        kind     [NUM_FU];
  logic [LAT_W-1:0] load_cnt [NUM_FU];

  for (genvar f = 0; f < NUM_FU; f++) begin : g_arr
    logic [TS_W-1:0] elapsed, lat_ext;
    assign elapsed = now_i - res_ts_i[f*TS_W +: TS_W];
    assign lat_ext = TS_W'(res_lat_i[f*LAT_W +: LAT_W]);
    assign kind[f] = (elapsed >= lat_ext) ? ARR_LATE : ARR_ON_TIME;
    assign load_cnt[f] = (kind[f] == ARR_LATE) ? '0 : LAT_W'(lat_ext - elapsed - 1'b1);
    assign late_o[f] = res_vld_i[f] && (kind[f] == ARR_LATE);
  end

  // retire pick: first NWP due entries by index
  logic [DEPTH-1:0] due, ret_mask;
  logic [IDX_W-1:0] pick    [NWP];
  logic [NWP-1:0]   pick_ok;

  always_comb begin
    ret_mask = '0;
    for (int p = 0; p < NWP; p++) begin
      pick[p]    = '0;
      pick_ok[p] = 1'b0;
    end
    for (int i = 0; i < DEPTH; i++) begin
      due[i] = vld_q[i] && (ent_q[i].cnt == '0);
      for (int p = 0; p < NWP; p++)
        if (due[i] && !ret_mask[i] && !pick_ok[p]) begin
          pick[p]     = IDX_W'(i);
          pick_ok[p]  = 1'b1;
          ret_mask[i] = 1'b1;
        end
    end
  end

  for (genvar p = 0; p < NWP; p++) begin : g_ret
    assign ret_vld_o[p]                 = pick_ok[p];
    assign ret_dest_o[p*REG_W +: REG_W]  = ent_q[pick[p]].dest;
    assign ret_data_o[p*DATA_W +: DATA_W] = ent_q[pick[p]].data;
    assign ret_age_o[p*TS_W +: TS_W]     = now_i - ent_q[pick[p]].ts;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (ret_mask[i])                         vld_q[i] <= 1'b0;
        else if (vld_q[i] && ent_q[i].cnt != '0) ent_q[i].cnt <= ent_q[i].cnt - 1'b1;
      for (int f = 0; f < NUM_FU; f++)
        if (res_vld_i[f] && slot_ok[f]) begin
          vld_q[slot[f]] <= 1'b1;
          ent_q[slot[f]] <= '{dest: res_dest_i[f*REG_W +: REG_W],
                              data: res_data_i[f*DATA_W +: DATA_W],
                              ts:   res_ts_i[f*TS_W +: TS_W],
                              cnt:  load_cnt[f]};
        end
    end
  end

  // occupancy and backpressure
  logic [CNT_W-1:0] free_cnt, arr_cnt;
  always_comb begin
    free_cnt = '0;
    arr_cnt  = '0;
    for (int i = 0; i < DEPTH; i++) free_cnt += CNT_W'(!vld_q[i]);
    for (int f = 0; f < NUM_FU; f++) arr_cnt += CNT_W'(res_vld_i[f]);
  end

  assign stall_o = free_cnt < CNT_W'(STALL_FREE);

  // R2
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_cnt <= free_cnt);

  for (genvar i = 0; i < DEPTH; i++) begin : g_hold_chk
    // R9
    early_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_q[i] && ent_q[i].cnt != '0) |=> vld_q[i]);
  end
endmodule

// File: rtl/wbdb_top.sv
module wbdb_top #(
  parameter int unsigned NUM_FU     = 2,
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned REG_W      = 7,
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned LAT_W      = 5,
  parameter int unsigned TS_W       = 8,
  parameter int unsigned STALL_FREE = 4,
  localparam int unsigned NWP       = wbdb_pkg::WB_PORTS,
  localparam int unsigned NREG      = 1 << REG_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  output logic [TS_W-1:0]           now_o,
  input  logic [NUM_FU-1:0]         issue_vld_i,
  input  logic [NUM_FU*REG_W-1:0]   issue_dest_i,
  input  logic [NUM_FU-1:0]         res_vld_i,
  input  logic [NUM_FU*REG_W-1:0]   res_dest_i,
  input  logic [NUM_FU*DATA_W-1:0]  res_data_i,
  input  logic [NUM_FU*TS_W-1:0]    res_ts_i,
  input  logic [NUM_FU*LAT_W-1:0]   res_lat_i,
  output logic [1:0]                wr_en_o,
  output logic [2*REG_W-1:0]        wr_addr_o,
  output logic [2*DATA_W-1:0]       wr_data_o,
  output logic [NREG-1:0]           pend_o,
  output logic                      stall_o,
  output logic                      late_err_o
);
  logic [TS_W-1:0]       now_q;
  logic [NWP-1:0]        ret_vld;
  logic [NWP*REG_W-1:0]  ret_dest;
  logic [NWP*DATA_W-1:0] ret_data;
  logic [NWP*TS_W-1:0]   ret_age;
  logic [NUM_FU-1:0]     late;
  logic                  err_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      now_q <= '0;
      err_q <= 1'b0;
    end else begin
      now_q <= now_q + 1'b1;
      err_q <= err_q | (|late);
    end

  wbdb_store #(
    .NUM_FU(NUM_FU), .DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W),
    .LAT_W(LAT_W), .TS_W(TS_W), .STALL_FREE(STALL_FREE)
  ) u_store (
    .clk_i, .rst_ni,
    .now_i      (now_q),
    .res_vld_i, .res_dest_i, .res_data_i, .res_ts_i, .res_lat_i,
    .ret_vld_o  (ret_vld),
    .ret_dest_o (ret_dest),
    .ret_data_o (ret_data),
    .ret_age_o  (ret_age),
    .late_o     (late),
    .stall_o
  );

  // same register on both ports: older issue (larger age) loses
  logic same_dest, drop0, drop1;
  assign same_dest = &ret_vld && (ret_dest[0 +: REG_W] == ret_dest[REG_W +: REG_W]);
  assign drop0     = same_dest && (ret_age[0 +: TS_W] >  ret_age[TS_W +: TS_W]);
  assign drop1     = same_dest && !drop0;

  assign wr_en_o   = ret_vld & ~{drop1, drop0};
  assign wr_addr_o = ret_dest;
  assign wr_data_o = ret_data;

  wbdb_pend #(.NUM_FU(NUM_FU), .REG_W(REG_W), .NUM_WP(NWP)) u_pend (
    .clk_i, .rst_ni,
    .issue_vld_i, .issue_dest_i,
    .clr_vld_i  (ret_vld),
    .clr_dest_i (ret_dest),
    .pend_o
  );

  assign now_o      = now_q;
  assign late_err_o = err_q;

  // R5
  same_dest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&wr_en_o) |-> (wr_addr_o[0 +: REG_W] != wr_addr_o[REG_W +: REG_W]));

  // R3
  late_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_err_o |=> late_err_o);

  // R1
  now_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_vld[0] |=> (now_o != $past(now_o)));
endmodule

// File: tb/tb_wbdb_top.sv
`timescale 1ns/1ps
module tb_wbdb_top;
  localparam int NF = 2, RW = 7, DW = 64, LW = 5, TW = 8, NR = 128;
  localparam int DEPTH = 16, SF = 4, NOPS = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [TW-1:0]    now_o;
  logic [NF-1:0]    issue_vld;
  logic [NF*RW-1:0] issue_dest;
  logic [NF-1:0]    res_vld;
  logic [NF*RW-1:0] res_dest;
  logic [NF*DW-1:0] res_data;
  logic [NF*TW-1:0] res_ts;
  logic [NF*LW-1:0] res_lat;
  logic [1:0]       wr_en;
  logic [2*RW-1:0]  wr_addr;
  logic [2*DW-1:0]  wr_data;
  logic [NR-1:0]    pend;
  logic             stall, late_err;

  wbdb_top dut (
    .clk_i(clk), .rst_ni(rst_n), .now_o(now_o),
    .issue_vld_i(issue_vld), .issue_dest_i(issue_dest),
    .res_vld_i(res_vld), .res_dest_i(res_dest), .res_data_i(res_data),
    .res_ts_i(res_ts), .res_lat_i(res_lat),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .pend_o(pend), .stall_o(stall), .late_err_o(late_err)
  );

  int errs = 0, checks = 0, cyc = 0;
  bit done = 0;

  bit          op_act [NOPS];
  bit          op_win [NOPS];
  bit          op_late[NOPS];
  int          op_dest[NOPS], op_ts[NOPS], op_lat[NOPS], op_arr[NOPS], op_due[NOPS], op_lane[NOPS];
  logic [DW-1:0] op_data[NOPS];
  logic [NR-1:0] pend_m = '0;
  bit          err_m = 0;
  logic [NF-1:0] iss_v = '0;
  int          iss_d[NF];

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, logic [NR-1:0] act, logic [NR-1:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic int inflight();
    int n = 0;
    for (int i = 0; i < NOPS; i++) n += op_act[i];
    return n;
  endfunction

  function automatic void add_op(int f, int dest, int lat, int e, bit win);
    for (int i = 0; i < NOPS; i++)
      if (!op_act[i]) begin
        op_act[i]  = 1; op_win[i] = win; op_dest[i] = dest;
        op_data[i] = {$urandom(), $urandom()};
        op_ts[i] = cyc; op_lat[i] = lat; op_arr[i] = cyc + e; op_lane[i] = f;
        op_late[i] = (e >= lat);
        op_due[i]  = op_late[i] ? cyc + e + 1 : cyc + lat;
        iss_v[f] = 1'b1; iss_d[f] = dest;
        return;
      end
  endfunction

  function automatic bit can_add(int f, int dest, int lat, int e);
    int nd = 0;
    if (inflight() >= 14) return 0;
    if (pend_m[dest]) return 0;
    for (int g = 0; g < NF; g++) if (iss_v[g] && iss_d[g] == dest) return 0;
    for (int i = 0; i < NOPS; i++) if (op_act[i]) begin
      if (op_dest[i] == dest) return 0;
      if (op_lane[i] == f && op_arr[i] == cyc + e) return 0;
      if (op_due[i] == cyc + lat) nd++;
    end
    return nd < 2;
  endfunction

  task automatic tick_check();
    int c, occ, nexp;
    bit used[NOPS];
    @(negedge clk);
    c = cyc;
    chk(now_o == TW'(c), "R1", "cycle stamp", NR'(now_o), NR'(TW'(c)));
    chk(pend == pend_m, "R6", "pending flags", pend, pend_m);
    occ = 0;
    for (int i = 0; i < NOPS; i++) if (op_act[i] && op_arr[i] < c && op_due[i] >= c) occ++;
    chk(stall == ((DEPTH - occ) < SF), "R7", "stall", NR'(stall), NR'((DEPTH - occ) < SF));
    chk(late_err == err_m, "R3", "late flag", NR'(late_err), NR'(err_m));
    nexp = 0;
    for (int i = 0; i < NOPS; i++) begin
      used[i] = 0;
      if (op_act[i] && op_due[i] == c && op_win[i]) nexp++;
    end
    for (int p = 0; p < 2; p++) if (wr_en[p]) begin
      bit found = 0;
      for (int i = 0; i < NOPS; i++)
        if (!found && op_act[i] && op_due[i] == c && op_win[i] && !used[i] &&
            op_dest[i] == int'(wr_addr[p*RW +: RW]) && op_data[i] == wr_data[p*DW +: DW]) begin
          used[i] = 1; found = 1;
        end
      chk(found, "R2", "write matches a due result", NR'(wr_data[p*DW +: DW]), NR'(wr_addr[p*RW +: RW]));
    end
    if (&wr_en)
      chk(wr_addr[0 +: RW] != wr_addr[RW +: RW], "R5", "distinct port addresses",
          NR'(wr_addr[0 +: RW]), NR'(wr_addr[RW +: RW]));
    // R4 / R9: exact number of writes this cycle, none early
    chk($countones(wr_en) == nexp, "R9", "write count", NR'($countones(wr_en)), NR'(nexp));
    for (int i = 0; i < NOPS; i++)
      if (op_act[i] && op_due[i] == c) begin
        pend_m[op_dest[i]] = 1'b0;
        op_act[i] = 0;
      end
  endtask

  task automatic tick_drive();
    res_vld = '0;
    for (int f = 0; f < NF; f++) begin
      issue_vld[f] = iss_v[f];
      issue_dest[f*RW +: RW] = RW'(iss_d[f]);
    end
    for (int i = 0; i < NOPS; i++)
      if (op_act[i] && op_arr[i] == cyc) begin
        res_vld[op_lane[i]] = 1'b1;
        res_dest[op_lane[i]*RW +: RW] = RW'(op_dest[i]);
        res_data[op_lane[i]*DW +: DW] = op_data[i];
        res_ts[op_lane[i]*TW +: TW]   = TW'(op_ts[i]);
        res_lat[op_lane[i]*LW +: LW]  = LW'(op_lat[i]);
        if (op_late[i]) err_m = 1;
      end
    for (int f = 0; f < NF; f++) if (iss_v[f]) pend_m[iss_d[f]] = 1'b1;
    iss_v = '0;
  endtask

  task automatic idle(int n);
    repeat (n) begin tick_check(); tick_drive(); end
  endtask

  initial begin
    void'($urandom(32'd4242));
    issue_vld = '0; issue_dest = '0; res_vld = '0; res_dest = '0;
    res_data = '0; res_ts = '0; res_lat = '0;
    for (int f = 0; f < NF; f++) iss_d[f] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 reset state
    chk(wr_en == 2'b00, "R8", "no write in reset", NR'(wr_en), '0);
    chk(pend == '0, "R8", "pending clear in reset", pend, '0);
    chk(!stall && !late_err, "R8", "stall/late low in reset", NR'({stall, late_err}), '0);
    rst_n = 1'b1;

    // R2 / R9: latency 1, result in issue cycle
    tick_check(); add_op(0, 5, 1, 0, 1); tick_drive();
    idle(3);
    // R2: latency 31, arrival at once and on last allowed cycle
    tick_check(); add_op(0, 10, 31, 0, 1); add_op(1, 11, 31, 30, 1); tick_drive();
    idle(33);
    // R3: late result
    tick_check(); add_op(0, 20, 3, 5, 1); tick_drive();
    idle(8);
    // R5: same register due together, later issue wins
    tick_check(); add_op(0, 9, 5, 1, 0); tick_drive();
    tick_check(); add_op(1, 9, 4, 0, 1); tick_drive();
    idle(7);
    // R7: fill with long latencies
    for (int k = 0; k < 7; k++) begin
      tick_check(); add_op(0, 30 + 2*k, 25, 0, 1); add_op(1, 31 + 2*k, 25, 0, 1); tick_drive();
    end
    idle(28);
    // R4 / R2 random traffic, stamp wraps many times
    for (int n = 0; n < 3000; n++) begin
      tick_check();
      for (int f = 0; f < NF; f++)
        if ($urandom() % 2) begin
          int lat = 1 + int'($urandom() % 10);
          int e   = int'($urandom() % lat);
          int d   = int'($urandom() % NR);
          if (can_add(f, d, lat, e)) add_op(f, d, lat, e, 1);
        end
      tick_drive();
    end
    idle(40);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(30000 * 5);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule